// File: doc/BRIEF.md
# Dual-Rate Waveform Table Player

This block reads two sample tables from on-chip RAM and merges them into one 8-bit DAC code. A fast channel walks its table at the system clock divided by a programmable factor. A slow channel walks a second table of the same length at a much lower rate, so one pass of the slow table lasts many passes of the fast one. The slow table therefore acts as an envelope on the fast waveform.

Both channels derive their rates from the 50 MHz system clock through integer dividers. A configuration is taken in a single cycle by pulsing `cfgLoad`, and the two channels then restart in phase. The host-side loading path and the table write ports belong to the surrounding design. The block only drives the read addresses and consumes the read data, which arrives one clock after each address.

Top module: `dualrate_player`

## Requirements
- R1: While `rstN` is low, both read addresses and `dacCode` are 0.
- R2: On the clock edge where `cfgLoad` is sampled high, the divider values and the last index are captured, and both divider counters are cleared. After that edge both read addresses are 0, so the two channels start in phase.
- R3: With a captured fast divider value F, `fastRdAddr` changes exactly once every F+1 clock cycles.
- R4: Each read address counts up by 1 from 0. When it steps while equal to the captured last index L, it returns to 0 instead, so it never exceeds L. With L = 0 the address stays at 0.
- R5: With a captured 16-bit slow divider value S, `slowRdAddr` changes exactly once every S+1 clock cycles. The upper 8 bits of S take part in the count.
- R6: The table RAM returns, on the clock after an address is presented, the sample stored at that address. `dacCode` is registered and, one clock after that data arrives, equals min(255, fast sample + slow sample) as an unsigned sum.
- R7: The configuration inputs have no effect unless `cfgLoad` is high. Changing them alone leaves the playback rates and the table length unchanged.
- R8: With fast division d = F+1 and N = L+1 points, the fast table repeats every d×N clocks. With S = ratio×d − 1, the slow table repeats every ratio×d×N clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | One-cycle strobe that captures the configuration and restarts playback |
| fastDivCfg | input | 8 | Fast division factor minus one |
| slowDivCfg | input | 16 | Slow division factor minus one |
| lastIdxCfg | input | 8 | Number of table points minus one |
| fastRdAddr | output | 8 | Read address of the fast table |
| fastRdData | input | 8 | Fast table sample, valid one clock after the address |
| slowRdAddr | output | 8 | Read address of the slow table |
| slowRdData | input | 8 | Slow table sample, valid one clock after the address |
| dacCode | output | 8 | Saturated sum of both samples, to the DAC |

## Verification
Each result has a fixed latency. Both addresses read 0 at the first edge after the load strobe. An address step lands on the edge that closes each run of F+1 (or S+1) cycles. A new sample reaches `dacCode` two edges after its address: one edge for the RAM and one for the output register. The bench drives inputs on falling edges and runs a behavioural model on the same rising edges, with its own RAM delay and divider arithmetic. Addresses and output are compared at every falling edge. Repeat periods are measured from the cycle counts between wraps to zero.

// File: rtl/dualrate_pkg.sv
package dualrate_pkg;

  typedef struct packed {
    logic restart;
    logic fastStep;
    logic slowStep;
  } rateStrobes_t;

  localparam int unsigned NUM_CHANNELS = 2;
  localparam int unsigned CH_FAST = 0;
  localparam int unsigned CH_SLOW = 1;

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic [CNT_W-1:0] divMax,
  output logic             step
);

  logic [CNT_W-1:0] cntQ;

  assign step = (cntQ == divMax);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (restart) begin
      cntQ <= '0;
    end else if (step) begin
      cntQ <= '0;
    end else begin
      cntQ <= cntQ + 1'b1;
    end
  end

endmodule

// File: rtl/rate_ctrl.sv
module rate_ctrl
  import dualrate_pkg::*;
#(
  parameter int unsigned FDIV_W = 8,
  parameter int unsigned SDIV_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [FDIV_W-1:0] fastDivCfg,
  input  logic [SDIV_W-1:0] slowDivCfg,
  input  logic [ADDR_W-1:0] lastIdxCfg,
  output rateStrobes_t      strobes,
  output logic [ADDR_W-1:0] lastIdx
);

  logic [FDIV_W-1:0] fastDivQ;
  logic [SDIV_W-1:0] slowDivQ;
  logic [ADDR_W-1:0] lastIdxQ;
  logic              fastTick;
  logic              slowTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastDivQ <= '0;
      slowDivQ <= '0;
      lastIdxQ <= '0;
    end else if (cfgLoad) begin
      fastDivQ <= fastDivCfg;
      slowDivQ <= slowDivCfg;
      lastIdxQ <= lastIdxCfg;
    end
  end

  tick_divider #(.CNT_W(FDIV_W)) fastDiv (
    .clk     (clk),
    .rstN    (rstN),
    .restart (cfgLoad),
    .divMax  (fastDivQ),
    .step    (fastTick)
  );

  tick_divider #(.CNT_W(SDIV_W)) slowDiv (
    .clk     (clk),
    .rstN    (rstN),
    .restart (cfgLoad),
    .divMax  (slowDivQ),
    .step    (slowTick)
  );

  always_comb begin
    strobes.restart  = cfgLoad;
    strobes.fastStep = fastTick && !cfgLoad;
    strobes.slowStep = slowTick && !cfgLoad;
  end

  assign lastIdx = lastIdxQ;

endmodule

// File: rtl/sample_path.sv
module sample_path
  import dualrate_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rateStrobes_t      strobes,
  input  logic [ADDR_W-1:0] lastIdx,
  input  logic [DATA_W-1:0] fastRdData,
  input  logic [DATA_W-1:0] slowRdData,
  output logic [ADDR_W-1:0] fastRdAddr,
  output logic [ADDR_W-1:0] slowRdAddr,
  output logic [DATA_W-1:0] dacCode
);

  localparam int unsigned SUM_W = DATA_W + 1;

  logic [ADDR_W-1:0] addrQ [NUM_CHANNELS];
  logic              stepVec [NUM_CHANNELS];
  logic [SUM_W-1:0]  rawSum;
  logic [DATA_W-1:0] satSum;

  assign stepVec[CH_FAST] = strobes.fastStep;
  assign stepVec[CH_SLOW] = strobes.slowStep;

  for (genvar ch = 0; ch < NUM_CHANNELS; ch++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrQ[ch] <= '0;
      end else if (strobes.restart) begin
        addrQ[ch] <= '0;
      end else if (stepVec[ch]) begin
        addrQ[ch] <= (addrQ[ch] == lastIdx) ? '0 : addrQ[ch] + 1'b1;
      end
    end
  end

  assign fastRdAddr = addrQ[CH_FAST];
  assign slowRdAddr = addrQ[CH_SLOW];

  always_comb begin
    rawSum = {1'b0, fastRdData} + {1'b0, slowRdData};
    satSum = rawSum[DATA_W] ? {DATA_W{1'b1}} : rawSum[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode <= '0;
    end else begin
      dacCode <= satSum;
    end
  end

endmodule

// File: rtl/dualrate_player.sv
module dualrate_player
  import dualrate_pkg::*;
#(
  parameter int unsigned FDIV_W = 8,
  parameter int unsigned SDIV_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [FDIV_W-1:0] fastDivCfg,
  input  logic [SDIV_W-1:0] slowDivCfg,
  input  logic [ADDR_W-1:0] lastIdxCfg,
  output logic [ADDR_W-1:0] fastRdAddr,
  input  logic [DATA_W-1:0] fastRdData,
  output logic [ADDR_W-1:0] slowRdAddr,
  input  logic [DATA_W-1:0] slowRdData,
  output logic [DATA_W-1:0] dacCode
);

  rateStrobes_t      strobes;
  logic [ADDR_W-1:0] lastIdx;

  rate_ctrl #(
    .FDIV_W (FDIV_W),
    .SDIV_W (SDIV_W),
    .ADDR_W (ADDR_W)
  ) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgLoad    (cfgLoad),
    .fastDivCfg (fastDivCfg),
    .slowDivCfg (slowDivCfg),
    .lastIdxCfg (lastIdxCfg),
    .strobes    (strobes),
    .lastIdx    (lastIdx)
  );

  sample_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) path (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .lastIdx    (lastIdx),
    .fastRdData (fastRdData),
    .slowRdData (slowRdData),
    .fastRdAddr (fastRdAddr),
    .slowRdAddr (slowRdAddr),
    .dacCode    (dacCode)
  );

endmodule

// File: rtl/dualrate_player_checker.sv
module dualrate_player_checker #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgLoad,
  input logic [ADDR_W-1:0] lastIdx,
  input logic [ADDR_W-1:0] fastRdAddr,
  input logic [ADDR_W-1:0] slowRdAddr,
  input logic [DATA_W-1:0] fastRdData,
  input logic [DATA_W-1:0] slowRdData,
  input logic [DATA_W-1:0] dacCode
);

  function automatic logic [DATA_W-1:0] satAdd(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    logic [DATA_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DATA_W] ? {DATA_W{1'b1}} : s[DATA_W-1:0];
  endfunction

  always_comb begin
    if (!rstN) begin
      assert_reset_idle_R1: assert (fastRdAddr == '0 && slowRdAddr == '0 && dacCode == '0);
    end
  end

  assert_load_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> (fastRdAddr == '0 && slowRdAddr == '0));

  assert_fast_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fastRdAddr) |-> (fastRdAddr == '0 || fastRdAddr == $past(fastRdAddr) + 1'b1));

  assert_addr_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fastRdAddr <= lastIdx && slowRdAddr <= lastIdx));

  assert_slow_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(slowRdAddr) |-> (slowRdAddr == '0 || slowRdAddr == $past(slowRdAddr) + 1'b1));

  assert_sat_sum_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (dacCode == satAdd($past(fastRdData), $past(slowRdData))));

endmodule

bind dualrate_player dualrate_player_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgLoad    (cfgLoad),
  .lastIdx    (lastIdx),
  .fastRdAddr (fastRdAddr),
  .slowRdAddr (slowRdAddr),
  .fastRdData (fastRdData),
  .slowRdData (slowRdData),
  .dacCode    (dacCode)
);

// File: tb/dualrate_player_test.sv
module dualrate_player_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [7:0]  fastDivCfg = '0;
  logic [15:0] slowDivCfg = '0;
  logic [7:0]  lastIdxCfg = '0;
  logic [7:0]  fastRdAddr, slowRdAddr, dacCode;
  logic [7:0]  fastRdData, slowRdData;

  logic [7:0] fMem [256];
  logic [7:0] sMem [256];

  int compared = 0;
  int mismatched = 0;
  int cycle = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dualrate_player uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad),
    .fastDivCfg(fastDivCfg), .slowDivCfg(slowDivCfg), .lastIdxCfg(lastIdxCfg),
    .fastRdAddr(fastRdAddr), .fastRdData(fastRdData),
    .slowRdAddr(slowRdAddr), .slowRdData(slowRdData),
    .dacCode(dacCode)
  );

  // table RAMs with one clock of read latency
  always @(posedge clk) begin
    fastRdData <= fMem[fastRdAddr];
    slowRdData <= sMem[slowRdAddr];
  end

  // behavioural reference model
  int mF, mS, mL, fCnt, sCnt, fAddr, sAddr, mFData, mSData, mDac;
  always @(posedge clk or negedge rstN) begin
    int nd;
    if (!rstN) begin
      mF = 0; mS = 0; mL = 0; fCnt = 0; sCnt = 0; fAddr = 0; sAddr = 0;
      mFData = fMem[0]; mSData = sMem[0]; mDac = 0;
    end else begin
      nd = mFData + mSData;
      if (nd > 255) nd = 255;
      mFData = fMem[fAddr];
      mSData = sMem[sAddr];
      if (cfgLoad) begin
        mF = fastDivCfg; mS = slowDivCfg; mL = lastIdxCfg;
        fCnt = 0; sCnt = 0; fAddr = 0; sAddr = 0;
      end else begin
        if (fCnt == mF) begin
          fCnt = 0;
          fAddr = (fAddr == mL) ? 0 : fAddr + 1;
        end else fCnt++;
        if (sCnt == mS) begin
          sCnt = 0;
          sAddr = (sAddr == mL) ? 0 : sAddr + 1;
        end else sCnt++;
      end
      mDac = nd;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycle);
    end
  endtask

  // period monitor, wraps to zero
  int fPrev = 0, sPrev = 0, fWrap = 0, sWrap = 0, fPer = 0, sPer = 0;
  always @(negedge clk) begin
    cycle++;
    if (rstN) begin
      check(fastRdAddr == fAddr[7:0], "R3 R4 fast address", fastRdAddr, fAddr);
      check(slowRdAddr == sAddr[7:0], "R5 R4 slow address", slowRdAddr, sAddr);
      check(dacCode == mDac[7:0], "R6 dac code", dacCode, mDac);
      if (fastRdAddr == 0 && fPrev != 0) begin fPer = cycle - fWrap; fWrap = cycle; end
      if (slowRdAddr == 0 && sPrev != 0) begin sPer = cycle - sWrap; sWrap = cycle; end
      fPrev = fastRdAddr;
      sPrev = slowRdAddr;
    end
  end

  task automatic fillTables(input bit loud);
    for (int i = 0; i < 256; i++) begin
      fMem[i] = loud ? 8'(200 - (i % 50)) : 8'((i * 7) % 60);
      sMem[i] = loud ? 8'(100 + (i % 40)) : 8'((i * 3) % 50);
    end
  endtask

  task automatic loadCfg(input int f, input int s, input int l);
    @(negedge clk);
    fastDivCfg = 8'(f); slowDivCfg = 16'(s); lastIdxCfg = 8'(l);
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    check(fastRdAddr == 0 && slowRdAddr == 0, "R2 both addresses zero after load",
          {fastRdAddr, slowRdAddr}, 0);
  endtask

  task automatic runCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkPeriods(input int expF, input int expS, input string tag);
    check(fPer == expF, {tag, " fast period"}, fPer, expF);
    check(sPer == expS, {tag, " slow period"}, sPer, expS);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    fillTables(1'b0);
    repeat (4) @(negedge clk);
    // R1: idle values held during reset
    check(fastRdAddr == 0 && slowRdAddr == 0, "R1 addresses in reset", fastRdAddr, 0);
    check(dacCode == 0, "R1 dac in reset", dacCode, 0);
    rstN = 1'b1;
    runCycles(5);

    // R8: d=3, N=8, ratio 4 -> S=11
    loadCfg(2, 11, 7);
    runCycles(400);
    checkPeriods(24, 96, "R8 d3 N8");

    // R7: new values presented without the load strobe
    fastDivCfg = 8'd9; slowDivCfg = 16'd1; lastIdxCfg = 8'd2;
    runCycles(300);
    checkPeriods(24, 96, "R7 unloaded config ignored");

    // R4: single-point table stays at index 0
    loadCfg(0, 0, 0);
    runCycles(50);
    check(fastRdAddr == 0 && slowRdAddr == 0, "R4 single point stays zero",
          {fastRdAddr, slowRdAddr}, 0);

    // R6: saturation with full-length table, divider of one
    fillTables(1'b1);
    loadCfg(0, 1, 255);
    runCycles(1300);
    checkPeriods(256, 512, "R8 N256");
    check(dacCode == 8'hFF || dacCode == mDac[7:0], "R6 saturated output", dacCode, mDac);

    // R5: slow divider using the high byte, S=0x0103, d=5, N=4
    fillTables(1'b0);
    loadCfg(4, 16'h0103, 3);
    runCycles(3200);
    checkPeriods(20, 1040, "R5 sixteen bit slow divider");

    // R2: reload mid-stream restarts in phase
    runCycles(37);
    loadCfg(1, 7, 5);
    runCycles(200);
    checkPeriods(12, 48, "R2 reload in phase");

    finishRun();
  end

endmodule